// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold and Draining Events

This block holds the two byte queues that sit between a serial bus engine and the register interface of a controller. The transmit queue is filled through a data register write port and emptied by the bus engine one byte at a time. The receive queue is filled by the bus engine and emptied through a data register read port. Each queue has its own programmable threshold. A ready event tells software that a whole threshold-sized block can be moved.

A transfer-length counter tracks how many bytes of the current transfer have not yet crossed the bus. When the bytes still to be moved can no longer make up a full threshold block, the block raises a draining event instead of the ready event. Software can then move the final partial block without waiting for a threshold that will never be reached.

Software programs both thresholds and two one-shot queue clears through a single 16-bit configuration word. The queue depth is fixed at elaboration and is reported as a code.

Top module: `dual_fifo_events`

## Requirements
- R1: Configuration word fields set the thresholds. Bits [5:0] hold the transmit threshold minus one and bits [13:8] hold the receive threshold minus one, so each threshold is 1 to 64. Both thresholds are 1 after reset.
- R2: evRxReady is high whenever the receive level is greater than or equal to the receive threshold.
- R3: evRxDrain is high only in a receive transfer (lenDirRx=1 at load), and only when three conditions hold together: the remaining count is zero, the receive level is nonzero, and the level is below the receive threshold.
- R4: In a transmit transfer, evTxReady is high when both conditions hold: the transmit level is below the transmit threshold, and the bytes not yet written are at least the threshold. The bytes not yet written are the remaining count minus the transmit level, taken as zero if negative.
- R5: In a transmit transfer, evTxDrain is high when the bytes not yet written are nonzero and below the transmit threshold. evTxReady and evTxDrain are never high together. Neither is high in a receive transfer.
- R6: Writing configuration bit 6 empties the transmit queue, and bit 14 empties the receive queue, by the next cycle. A clear overrides any push or pop in the same cycle. The clear bits are not stored: a later write with the bit low clears nothing.
- R7: Each queue returns bytes in arrival order, and its level is the number of bytes held. A bus push into a full receive queue is dropped.
- R8: regRdata is 0 while the receive queue is empty. A read of an empty receive queue leaves the level at 0.
- R9: A register write into a full transmit queue is dropped and sets txOverflow. txOverflow stays set until a transmit clear.
- R10: depthCode equals DEPTH_CODE, and each queue holds 8 shifted left by that code bytes (8 by default).
- R11: A length write with a nonzero value loads the remaining count and the direction. A length write of zero is ignored. The count drops by one for each accepted bus pop in a transmit transfer, and for each accepted bus push in a receive transfer.
- R12: After reset, both levels are 0, all four events are low, and txOverflow is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration word write strobe |
| cfgData | input | 16 | Thresholds minus one ([5:0] tx, [13:8] rx), clears (bit 6 tx, bit 14 rx) |
| lenWe | input | 1 | Transfer length write strobe |
| lenData | input | LEN_W | Transfer length in bytes (zero ignored) |
| lenDirRx | input | 1 | Direction loaded with the length: 1 receive, 0 transmit |
| regWrite | input | 1 | Data register write (push transmit queue) |
| regWdata | input | 8 | Byte written to the transmit queue |
| regRead | input | 1 | Data register read (pop receive queue) |
| regRdata | output | 8 | Receive queue head, 0 when empty |
| busTxPop | input | 1 | Bus engine takes the transmit head |
| busTxData | output | 8 | Transmit queue head, 0 when empty |
| busRxPush | input | 1 | Bus engine delivers a received byte |
| busRxData | input | 8 | Received byte |
| txLevel | output | LVL_W | Bytes held in the transmit queue |
| rxLevel | output | LVL_W | Bytes held in the receive queue |
| depthCode | output | 3 | Depth code: depth = 8 << depthCode |
| evTxReady | output | 1 | Transmit threshold block can be written |
| evTxDrain | output | 1 | Final partial transmit block can be written |
| evRxReady | output | 1 | Receive threshold block available |
| evRxDrain | output | 1 | Final partial receive block available |
| txOverflow | output | 1 | Sticky dropped-write flag |

## Verification
A wrong pointer or level shows up at once on the head-byte outputs and on the level ports. It also appears on the next pop as a byte out of order. The sweeps compare every popped byte with the pushed sequence.

A wrong remaining count or a threshold mistake shows up on the event pins in the very cycle after the step that went wrong. Every threshold from 1 to 8 and every length from 1 to 12 is walked in both directions, with the events compared in every cycle.

A clear or a sticky flag that misbehaves shows on the level and txOverflow one cycle after the configuration write.

// File: rtl/dfe_pkg.sv
package dfe_pkg;
  localparam int BYTE_W      = 8;
  localparam int CFG_W       = 16;
  localparam int THR_FIELD_W = 6;
  localparam int TX_THR_LSB  = 0;
  localparam int RX_THR_LSB  = 8;
  localparam int TX_CLR_BIT  = 6;
  localparam int RX_CLR_BIT  = 14;
  localparam int CH_TX       = 0;
  localparam int CH_RX       = 1;

  // Per-queue command strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic push;
    logic pop;
  } fifoCmd_t;
endpackage

// File: rtl/dfe_datapath.sv
module dfe_datapath
  import dfe_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fifoCmd_t [1:0]              cmd,
  input  logic [1:0][BYTE_W-1:0]      wrByte,
  output logic [1:0][LVL_W-1:0]       level,
  output logic [1:0][BYTE_W-1:0]      headByte
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  for (genvar ch = 0; ch < 2; ch++) begin : gCh
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wrPtr;
    logic [PTR_W-1:0]  rdPtr;
    logic [LVL_W-1:0]  lvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        lvl   <= '0;
      end else if (cmd[ch].clr) begin
        wrPtr <= '0;
        rdPtr <= '0;
        lvl   <= '0;
      end else begin
        if (cmd[ch].push) wrPtr <= wrPtr + 1'b1;
        if (cmd[ch].pop)  rdPtr <= rdPtr + 1'b1;
        case ({cmd[ch].push, cmd[ch].pop})
          2'b10:   lvl <= lvl + 1'b1;
          2'b01:   lvl <= lvl - 1'b1;
          default: lvl <= lvl;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (cmd[ch].push && !cmd[ch].clr) mem[wrPtr] <= wrByte[ch];
    end

    assign level[ch]    = lvl;
    assign headByte[ch] = (lvl == '0) ? '0 : mem[rdPtr];
  end
endmodule

// File: rtl/dfe_ctrl.sv
module dfe_ctrl
  import dfe_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4,
  parameter int LEN_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [CFG_W-1:0]       cfgData,
  input  logic                   lenWe,
  input  logic [LEN_W-1:0]       lenData,
  input  logic                   lenDirRx,
  input  logic                   regWrite,
  input  logic                   regRead,
  input  logic                   busTxPop,
  input  logic                   busRxPush,
  input  logic [1:0][LVL_W-1:0]  level,
  output fifoCmd_t [1:0]         cmd,
  output logic                   txOverflow,
  output logic                   evTxReady,
  output logic                   evTxDrain,
  output logic                   evRxReady,
  output logic                   evRxDrain
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [THR_FIELD_W:0] txThr;
  logic [THR_FIELD_W:0] rxThr;
  logic [LEN_W-1:0]     remaining;
  logic                 dirRx;

  logic clrTx, clrRx, txFull, txEmpty, rxFull, rxEmpty, countStep;

  assign clrTx   = cfgWe && cfgData[TX_CLR_BIT];
  assign clrRx   = cfgWe && cfgData[RX_CLR_BIT];
  assign txFull  = (level[CH_TX] == FULL_LVL);
  assign txEmpty = (level[CH_TX] == '0);
  assign rxFull  = (level[CH_RX] == FULL_LVL);
  assign rxEmpty = (level[CH_RX] == '0);

  always_comb begin
    cmd[CH_TX].clr  = clrTx;
    cmd[CH_TX].push = regWrite && !txFull && !clrTx;
    cmd[CH_TX].pop  = busTxPop && !txEmpty && !clrTx;
    cmd[CH_RX].clr  = clrRx;
    cmd[CH_RX].push = busRxPush && !rxFull && !clrRx;
    cmd[CH_RX].pop  = regRead && !rxEmpty && !clrRx;
  end

  assign countStep = dirRx ? cmd[CH_RX].push : cmd[CH_TX].pop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr      <= (THR_FIELD_W+1)'(1);
      rxThr      <= (THR_FIELD_W+1)'(1);
      remaining  <= '0;
      dirRx      <= 1'b0;
      txOverflow <= 1'b0;
    end else begin
      if (cfgWe) begin
        txThr <= {1'b0, cfgData[TX_THR_LSB +: THR_FIELD_W]} + 1'b1;
        rxThr <= {1'b0, cfgData[RX_THR_LSB +: THR_FIELD_W]} + 1'b1;
      end
      if (lenWe && (lenData != '0)) begin
        remaining <= lenData;
        dirRx     <= lenDirRx;
      end else if (countStep && (remaining != '0)) begin
        remaining <= remaining - 1'b1;
      end
      if (clrTx)                    txOverflow <= 1'b0;
      else if (regWrite && txFull)  txOverflow <= 1'b1;
    end
  end

  logic [LEN_W-1:0] txLvlX, rxLvlX, txThrX, rxThrX, unwritten;

  always_comb begin
    txLvlX    = LEN_W'(level[CH_TX]);
    rxLvlX    = LEN_W'(level[CH_RX]);
    txThrX    = LEN_W'(txThr);
    rxThrX    = LEN_W'(rxThr);
    unwritten = (remaining > txLvlX) ? (remaining - txLvlX) : '0;

    evRxReady = (rxLvlX >= rxThrX);
    evRxDrain = dirRx && (remaining == '0) && (rxLvlX != '0) && (rxLvlX < rxThrX);
    evTxReady = !dirRx && (txLvlX < txThrX) && (unwritten >= txThrX);
    evTxDrain = !dirRx && (unwritten != '0) && (unwritten < txThrX);
  end
endmodule

// File: rtl/dual_fifo_events.sv
module dual_fifo_events
  import dfe_pkg::*;
#(
  parameter int DEPTH_CODE = 0,
  parameter int LEN_W      = 16,
  localparam int DEPTH     = 8 << DEPTH_CODE,
  localparam int LVL_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [15:0]       cfgData,
  input  logic              lenWe,
  input  logic [LEN_W-1:0]  lenData,
  input  logic              lenDirRx,
  input  logic              regWrite,
  input  logic [7:0]        regWdata,
  input  logic              regRead,
  output logic [7:0]        regRdata,
  input  logic              busTxPop,
  output logic [7:0]        busTxData,
  input  logic              busRxPush,
  input  logic [7:0]        busRxData,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic [2:0]        depthCode,
  output logic              evTxReady,
  output logic              evTxDrain,
  output logic              evRxReady,
  output logic              evRxDrain,
  output logic              txOverflow
);
  fifoCmd_t [1:0]          cmd;
  logic [1:0][LVL_W-1:0]   level;
  logic [1:0][BYTE_W-1:0]  wrByte;
  logic [1:0][BYTE_W-1:0]  headByte;

  assign wrByte[CH_TX] = regWdata;
  assign wrByte[CH_RX] = busRxData;

  dfe_ctrl #(.DEPTH(DEPTH), .LVL_W(LVL_W), .LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .lenWe(lenWe), .lenData(lenData), .lenDirRx(lenDirRx),
    .regWrite(regWrite), .regRead(regRead), .busTxPop(busTxPop),
    .busRxPush(busRxPush), .level(level), .cmd(cmd), .txOverflow(txOverflow),
    .evTxReady(evTxReady), .evTxDrain(evTxDrain),
    .evRxReady(evRxReady), .evRxDrain(evRxDrain)
  );

  dfe_datapath #(.DEPTH(DEPTH), .LVL_W(LVL_W)) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrByte(wrByte),
    .level(level), .headByte(headByte)
  );

  assign txLevel   = level[CH_TX];
  assign rxLevel   = level[CH_RX];
  assign busTxData = headByte[CH_TX];
  assign regRdata  = headByte[CH_RX];
  assign depthCode = 3'(DEPTH_CODE);
endmodule

// File: rtl/dual_fifo_events_chk.sv
module dual_fifo_events_chk #(
  parameter int DEPTH_CODE = 0,
  parameter int LEN_W      = 16,
  localparam int DEPTH     = 8 << DEPTH_CODE,
  localparam int LVL_W     = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWe,
  input logic [15:0]      cfgData,
  input logic             regWrite,
  input logic             regRead,
  input logic [7:0]       regRdata,
  input logic             busTxPop,
  input logic             busRxPush,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             evTxReady,
  input logic             evTxDrain,
  input logic             evRxReady,
  input logic             evRxDrain,
  input logic             txOverflow
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  a_r3_rx_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(evRxReady && evRxDrain));
  a_r5_tx_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(evTxReady && evTxDrain));
  a_r6_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData[6]) |=> (txLevel == '0));
  a_r6_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData[14]) |=> (rxLevel == '0));
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= FULL_LVL) && (rxLevel <= FULL_LVL));
  a_r8_empty_head_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == '0) |-> (regRdata == 8'd0));
  a_r8_empty_read_no_move: assert property (@(posedge clk) disable iff (!rstN)
    ((rxLevel == '0) && regRead && !busRxPush) |=> (rxLevel == '0));
  a_r9_overflow_set: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && (txLevel == FULL_LVL) && !busTxPop && !(cfgWe && cfgData[6]))
      |=> (txOverflow && (txLevel == FULL_LVL)));
  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txOverflow && !(cfgWe && cfgData[6])) |=> txOverflow);
endmodule

bind dual_fifo_events dual_fifo_events_chk #(.DEPTH_CODE(DEPTH_CODE), .LEN_W(LEN_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
  .regWrite(regWrite), .regRead(regRead), .regRdata(regRdata),
  .busTxPop(busTxPop), .busRxPush(busRxPush),
  .txLevel(txLevel), .rxLevel(rxLevel),
  .evTxReady(evTxReady), .evTxDrain(evTxDrain),
  .evRxReady(evRxReady), .evRxDrain(evRxDrain), .txOverflow(txOverflow)
);

// File: tb/sim_dual_fifo_events.sv
`timescale 1ns/1ps
module sim_dual_fifo_events;
  localparam int DEPTH = 8;
  localparam int LVL_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, lenWe = 0, lenDirRx = 0, regWrite = 0, regRead = 0;
  logic busTxPop = 0, busRxPush = 0;
  logic [15:0] cfgData = '0;
  logic [15:0] lenData = '0;
  logic [7:0]  regWdata = '0, busRxData = '0;
  logic [7:0]  regRdata, busTxData;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic [2:0] depthCode;
  logic evTxReady, evTxDrain, evRxReady, evRxDrain, txOverflow;

  int checks = 0;
  int errs = 0;

  always #10 clk = ~clk;

  dual_fifo_events u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData),
    .lenWe(lenWe), .lenData(lenData), .lenDirRx(lenDirRx),
    .regWrite(regWrite), .regWdata(regWdata), .regRead(regRead), .regRdata(regRdata),
    .busTxPop(busTxPop), .busTxData(busTxData), .busRxPush(busRxPush), .busRxData(busRxData),
    .txLevel(txLevel), .rxLevel(rxLevel), .depthCode(depthCode),
    .evTxReady(evTxReady), .evTxDrain(evTxDrain), .evRxReady(evRxReady),
    .evRxDrain(evRxDrain), .txOverflow(txOverflow)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cfgWe = 0; lenWe = 0; regWrite = 0; regRead = 0; busTxPop = 0; busRxPush = 0;
  endtask

  task automatic setCfg(input int txT, input int rxT, input bit clrTx, input bit clrRx);
    cfgData = '0;
    cfgData[5:0]  = 6'(txT - 1);
    cfgData[13:8] = 6'(rxT - 1);
    cfgData[6]    = clrTx;
    cfgData[14]   = clrRx;
    cfgWe = 1;
    step();
  endtask

  task automatic setLen(input int n, input bit rx);
    lenData = 16'(n); lenDirRx = rx; lenWe = 1;
    step();
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'(i * 37 + s * 11 + 5);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    step();
    // R12 reset state, R10 depth code
    chkEq("R12 txLevel", int'(txLevel), 0);
    chkEq("R12 rxLevel", int'(rxLevel), 0);
    chkEq("R12 events", int'({evTxReady, evTxDrain, evRxReady, evRxDrain}), 0);
    chkEq("R12 txOverflow", int'(txOverflow), 0);
    chkEq("R10 depthCode", int'(depthCode), 0);
    chkEq("R8 empty read data", int'(regRdata), 0);

    // R7 R9 R10: fill transmit queue past its depth of 8 << 0
    setCfg(1, 1, 1, 1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      regWrite = 1; regWdata = pat(i, 1);
      step();
      chkEq("R7 tx level on fill", int'(txLevel), (i + 1 > DEPTH) ? DEPTH : i + 1);
      chkEq("R9 overflow on fill", int'(txOverflow), (i >= DEPTH) ? 1 : 0);
    end
    chkEq("R10 depth from code", int'(txLevel), 8 << int'(depthCode));
    // R6 clear bits not stored, R9 sticky
    setCfg(1, 1, 0, 0);
    chkEq("R9 overflow sticky", int'(txOverflow), 1);
    chkEq("R6 no clear without bit", int'(txLevel), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chkEq("R7 tx order", int'(busTxData), int'(pat(i, 1)));
      busTxPop = 1;
      step();
      chkEq("R7 tx level on drain", int'(txLevel), DEPTH - 1 - i);
    end
    setCfg(1, 1, 1, 0);
    chkEq("R9 overflow cleared by tx clear", int'(txOverflow), 0);

    // R7 R8 receive full drop and empty read
    for (int i = 0; i < DEPTH + 1; i++) begin
      busRxPush = 1; busRxData = pat(i, 2);
      step();
    end
    chkEq("R7 rx full drop level", int'(rxLevel), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chkEq("R7 rx order", int'(regRdata), int'(pat(i, 2)));
      regRead = 1;
      step();
    end
    chkEq("R7 rx dropped byte absent", int'(rxLevel), 0);
    chkEq("R8 empty head zero", int'(regRdata), 0);
    regRead = 1;
    step();
    chkEq("R8 empty read keeps level", int'(rxLevel), 0);
    chkEq("R8 empty read data after", int'(regRdata), 0);

    // R6 clear overrides a push in the same cycle
    busRxPush = 1; busRxData = 8'h11; step();
    busRxPush = 1; busRxData = 8'h22; step();
    chkEq("R6 rx level before clear", int'(rxLevel), 2);
    busRxPush = 1; busRxData = 8'h33;
    setCfg(1, 1, 0, 1);
    chkEq("R6 rx clear with push", int'(rxLevel), 0);
    regWrite = 1; regWdata = 8'h44;
    setCfg(1, 1, 1, 0);
    chkEq("R6 tx clear with write", int'(txLevel), 0);

    // R1 threshold field encoding: 64 and 8
    setCfg(1, 64, 1, 1);
    for (int i = 0; i < DEPTH; i++) begin
      busRxPush = 1; busRxData = pat(i, 3); step();
    end
    chkEq("R1 rx threshold 64 not reached", int'(evRxReady), 0);
    setCfg(1, 8, 0, 0);
    chkEq("R1 rx threshold 8 reached", int'(evRxReady), 1);
    setCfg(1, 9, 0, 0);
    chkEq("R1 rx threshold 9 not reached", int'(evRxReady), 0);

    // R11 zero length ignored
    setCfg(1, 1, 1, 1);
    setLen(3, 0);
    chkEq("R11 tx ready after load", int'(evTxReady), 1);
    setLen(0, 1);
    chkEq("R11 zero length ignored ready", int'(evTxReady), 1);
    chkEq("R11 zero length ignored drain", int'(evTxDrain), 0);
    chkEq("R5 no rx drain in tx transfer", int'(evRxDrain), 0);

    // R4 R5 R11 transmit sweep
    for (int t = 1; t <= DEPTH; t++) begin
      for (int len = 1; len <= 12; len++) begin
        int rem, lvl, w, q, k;
        setCfg(t, 1, 1, 1);
        setLen(len, 0);
        rem = len; lvl = 0; w = 0; q = 0; k = 0;
        while ((rem > 0) && (k < 100)) begin
          int need;
          need = rem - lvl;
          chkEq("R4 evTxReady", int'(evTxReady), ((lvl < t) && (need >= t)) ? 1 : 0);
          chkEq("R5 evTxDrain", int'(evTxDrain), ((need > 0) && (need < t)) ? 1 : 0);
          if ((need > 0) && (lvl < DEPTH) && (((k + t) % 3) != 0 || lvl == 0)) begin
            regWrite = 1; regWdata = pat(w, t + len); w++; lvl++;
          end else begin
            chkEq("R7 tx sweep order", int'(busTxData), int'(pat(q, t + len)));
            busTxPop = 1; q++; lvl--; rem--;
          end
          step();
          k++;
        end
        chkEq("R11 tx count exhausted events", int'({evTxReady, evTxDrain}), 0);
      end
    end

    // R2 R3 R11 receive sweep
    for (int t = 1; t <= DEPTH; t++) begin
      for (int len = 1; len <= 12; len++) begin
        int rem, lvl, p, q, k;
        setCfg(1, t, 1, 1);
        setLen(len, 1);
        rem = len; lvl = 0; p = 0; q = 0; k = 0;
        while (((rem > 0) || (lvl > 0)) && (k < 100)) begin
          chkEq("R2 evRxReady", int'(evRxReady), (lvl >= t) ? 1 : 0);
          chkEq("R3 evRxDrain", int'(evRxDrain), ((rem == 0) && (lvl > 0) && (lvl < t)) ? 1 : 0);
          chkEq("R5 no tx events in rx transfer", int'({evTxReady, evTxDrain}), 0);
          if ((rem > 0) && (lvl < DEPTH) && ((lvl < t) || (((k + len) % 2) == 0))) begin
            busRxPush = 1; busRxData = pat(p, t * 3 + len); p++; lvl++; rem--;
          end else begin
            chkEq("R7 rx sweep order", int'(regRdata), int'(pat(q, t * 3 + len)));
            regRead = 1; q++; lvl--;
          end
          step();
          k++;
        end
        chkEq("R3 rx events idle at end", int'({evRxReady, evRxDrain}), 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule